// File: doc/BRIEF.md
# Shift Unit with Extension Register

This block is a shift and rotate unit that owns a private extension register (called MQ here) of the same width as the data path. Every operation sends its main output to the result port. Most operations also leave a rotated copy of the source in MQ, or merge bits out of MQ into the result. Because of this, a shift longer than one word can be built from two or more consecutive operations: the first leaves the bits that would otherwise be lost in MQ, and a later merge pulls them back in.

The amount comes from one of two places. The first is a register-style amount one bit wider than the shift index, whose top bit selects a special over-width path for the long forms. The second is a short immediate field, which never takes that path. The caller presents the operation with `in_vld_i`. Result, carry and MQ update together at the next clock edge, and `out_vld_o` pulses for that one cycle. A side port reads MQ at any time and writes it in cycles that carry no operation.

Top module: `mqsh_unit`

## Requirements
- R1: After synchronous reset (active low) the result, carry, MQ and output-valid are all zero.
- R2: The outputs change only at the edge that samples `in_vld_i` high. `out_vld_o` is high for exactly the cycle after each accepted operation, and the result holds its value in cycles without an operation.
- R3: Let n be the shift index. Code 0 gives result = src << n and MQ = rotate-left(src, n). Code 1 gives result = src >> n (zero fill) and MQ = rotate-right(src, n). For both codes the over-width amount bit has no effect.
- R4: Codes 2 (left) and 3 (right) match codes 0 and 1, except that a register amount with its top bit set forces the result to zero. MQ still receives the rotated source.
- R5: Code 4 merges left: rot = rotate-left(src, n), mask = all-ones << n, result = (rot AND mask) OR (old MQ AND NOT mask), then MQ = rot. Code 5 is the same with rotate-right and mask = all-ones >> n.
- R6: Code 6 (left, mask = all-ones << n) and code 7 (right, mask = all-ones >> n) leave MQ unchanged. With the top amount bit set, result = old MQ AND mask. Otherwise, result = (src shifted by n) OR (old MQ AND NOT mask).
- R7: Code 8 gives result = src shifted right by n with sign fill, and MQ = rotate-right(src, n). The carry is left unchanged.
- R8: Code 9 gives MQ = rotate-right(src, n). The result is the sign-filled right shift, or all copies of the sign bit when the top amount bit is set. Carry is cleared, then set only if src is negative and at least one 1 bit was shifted out; with the top bit set, every bit counts as shifted out.
- R9: With `imm_sel_i` high, n is taken from `amt_imm_i` and the over-width path is never taken, whatever `amt_reg_i` holds.
- R10: A shift index of zero is well defined: MQ receives src unchanged, plain shifts return src, and code 9 leaves carry clear.
- R11: Back-to-back operations use the MQ value written by the operation just before, with no stall.
- R12: With `in_vld_i` low, `mq_we_i` loads `mq_wdata_i` into MQ at the next edge. When both are high, the operation's MQ update wins. MQ holds when neither is active, and `mq_o` always shows it.
- R13: Codes 10 to 15 are undefined: they give a zero result and leave MQ and carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code (0 to 9 defined) |
| src_i | input | DATA_W | Source word |
| amt_reg_i | input | $clog2(DATA_W)+1 | Register-style amount; top bit selects the over-width path |
| imm_sel_i | input | 1 | Take the amount from the immediate field |
| amt_imm_i | input | $clog2(DATA_W) | Immediate shift index |
| mq_we_i | input | 1 | Side-port write of MQ |
| mq_wdata_i | input | DATA_W | Side-port write data |
| out_vld_o | output | 1 | Result of an operation is present |
| res_o | output | DATA_W | Result word |
| carry_o | output | 1 | Carry flag |
| mq_o | output | DATA_W | Current MQ value |

## Verification
The bench builds the unit with DATA_W = 8, so the register amount has four bits and the immediate has three. In that configuration every operation code, including the six undefined ones, is driven with every register amount (over-width bit included) against all 256 source words. The immediate path is swept over every index with the over-width bit held high to show that it is ignored. MQ is carried from each operation to the next through the whole sweep, so every merge reads a value that the previous operation wrote.

// File: rtl/mqsh_pkg.sv
// Package: shared operation codes for the MQ shift unit.
// Assumes a 4-bit operation field; codes above MQOP_SRA_CARRY are undefined.
package mqsh_pkg;

    typedef enum logic [3:0] {
        MQOP_SHL        = 4'd0,
        MQOP_SHR        = 4'd1,
        MQOP_SHL_LONG   = 4'd2,
        MQOP_SHR_LONG   = 4'd3,
        MQOP_MRG_L      = 4'd4,
        MQOP_MRG_R      = 4'd5,
        MQOP_SHL_FROMQ  = 4'd6,
        MQOP_SHR_FROMQ  = 4'd7,
        MQOP_SRA_EXT    = 4'd8,
        MQOP_SRA_CARRY  = 4'd9
    } mqsh_op_e;

    localparam int MQOP_W = 4;

endpackage

// File: rtl/mqsh_rotator.sv
// Module: logarithmic barrel rotator.
// Rotates data_i by amt_i positions, to the left when ROT_LEFT is 1 and to the
// right otherwise. Assumes W is a power of two with SH_W = log2(W).
module mqsh_rotator #(
    parameter int W        = 32,
    parameter int SH_W     = $clog2(W),
    parameter bit ROT_LEFT = 1'b1
) (
    input  logic [W-1:0]    data_i,
    input  logic [SH_W-1:0] amt_i,
    output logic [W-1:0]    data_o
);

    logic [W-1:0] stage [0:SH_W];

    assign stage[0] = data_i;

    // One stage per amount bit; stage s rotates by 2**s when its bit is set.
    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int K = 1 << s;
        logic [W-1:0] rotated;
        if (ROT_LEFT) begin : g_left
            assign rotated = (stage[s] << K) | (stage[s] >> (W - K));
        end else begin : g_right
            assign rotated = (stage[s] >> K) | (stage[s] << (W - K));
        end
        assign stage[s+1] = amt_i[s] ? rotated : stage[s];
    end

    assign data_o = stage[SH_W];

endmodule

// File: rtl/mqsh_mask_gen.sv
// Module: shift masks for a given index.
// mask_l_o keeps the bits a left shift by amt_i keeps; mask_r_o does the same
// for a right shift. An index of zero gives all ones for both.
module mqsh_mask_gen #(
    parameter int W    = 32,
    parameter int SH_W = $clog2(W)
) (
    input  logic [SH_W-1:0] amt_i,
    output logic [W-1:0]    mask_l_o,
    output logic [W-1:0]    mask_r_o
);

    localparam logic [W-1:0] ONES = {W{1'b1}};

    // Mask formation: all-ones shifted by the index in each direction.
    always_comb begin
        mask_l_o = ONES << amt_i;
        mask_r_o = ONES >> amt_i;
    end

endmodule

// File: rtl/mqsh_op_core.sv
// Module: combinational heart of the MQ shift unit.
// Computes result, next MQ and next carry for one operation from both
// rotations and both masks. Every plain shift is taken as a masked rotation,
// so no shift by the full width is ever formed. Undefined codes return zero
// and pass MQ and carry through unchanged.
module mqsh_op_core
    import mqsh_pkg::*;
#(
    parameter int W    = 32,
    parameter int SH_W = $clog2(W)
) (
    input  logic [MQOP_W-1:0] op_i,
    input  logic [W-1:0]      src_i,
    input  logic [SH_W-1:0]   amt_i,
    input  logic              big_i,
    input  logic [W-1:0]      mq_i,
    input  logic              carry_i,
    output logic [W-1:0]      res_o,
    output logic [W-1:0]      mq_nxt_o,
    output logic              carry_nxt_o
);

    logic [W-1:0] rot_l;
    logic [W-1:0] rot_r;
    logic [W-1:0] mask_l;
    logic [W-1:0] mask_r;
    logic [W-1:0] shl_v;
    logic [W-1:0] shr_v;
    logic [W-1:0] sar_v;
    logic         sign;
    logic         lost_one;
    mqsh_op_e     op;

    mqsh_rotator #(.W(W), .SH_W(SH_W), .ROT_LEFT(1'b1)) u_rot_l (
        .data_i (src_i),
        .amt_i  (amt_i),
        .data_o (rot_l)
    );

    mqsh_rotator #(.W(W), .SH_W(SH_W), .ROT_LEFT(1'b0)) u_rot_r (
        .data_i (src_i),
        .amt_i  (amt_i),
        .data_o (rot_r)
    );

    mqsh_mask_gen #(.W(W), .SH_W(SH_W)) u_mask (
        .amt_i    (amt_i),
        .mask_l_o (mask_l),
        .mask_r_o (mask_r)
    );

    // Derived shifts: plain and arithmetic forms built from masked rotations.
    always_comb begin
        op       = mqsh_op_e'(op_i);
        sign     = src_i[W-1];
        shl_v    = rot_l & mask_l;
        shr_v    = rot_r & mask_r;
        sar_v    = shr_v | ({W{sign}} & ~mask_r);
        lost_one = |(rot_r & ~mask_r);
    end

    // Operation select: result, MQ update and carry update per code.
    always_comb begin
        res_o       = '0;
        mq_nxt_o    = mq_i;
        carry_nxt_o = carry_i;
        unique case (op)
            MQOP_SHL: begin
                res_o    = shl_v;
                mq_nxt_o = rot_l;
            end
            MQOP_SHR: begin
                res_o    = shr_v;
                mq_nxt_o = rot_r;
            end
            MQOP_SHL_LONG: begin
                res_o    = big_i ? '0 : shl_v;
                mq_nxt_o = rot_l;
            end
            MQOP_SHR_LONG: begin
                res_o    = big_i ? '0 : shr_v;
                mq_nxt_o = rot_r;
            end
            MQOP_MRG_L: begin
                res_o    = (rot_l & mask_l) | (mq_i & ~mask_l);
                mq_nxt_o = rot_l;
            end
            MQOP_MRG_R: begin
                res_o    = (rot_r & mask_r) | (mq_i & ~mask_r);
                mq_nxt_o = rot_r;
            end
            MQOP_SHL_FROMQ: begin
                res_o = big_i ? (mq_i & mask_l) : (shl_v | (mq_i & ~mask_l));
            end
            MQOP_SHR_FROMQ: begin
                res_o = big_i ? (mq_i & mask_r) : (shr_v | (mq_i & ~mask_r));
            end
            MQOP_SRA_EXT: begin
                res_o    = sar_v;
                mq_nxt_o = rot_r;
            end
            MQOP_SRA_CARRY: begin
                res_o       = big_i ? {W{sign}} : sar_v;
                mq_nxt_o    = rot_r;
                carry_nxt_o = sign & (big_i | lost_one);
            end
            default: begin
                res_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/mqsh_unit.sv
// Module: shift unit with MQ extension register (top).
// Accepts one operation per cycle on in_vld_i and registers result, carry
// and MQ together, presenting them one cycle later with out_vld_o.
// Assumes DATA_W is a power of two. The side port writes MQ only in cycles
// without an operation; an operation's MQ update takes priority.
module mqsh_unit
    import mqsh_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int AMT_W = SH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [AMT_W-1:0]  amt_reg_i,
    input  logic              imm_sel_i,
    input  logic [SH_W-1:0]   amt_imm_i,
    input  logic              mq_we_i,
    input  logic [DATA_W-1:0] mq_wdata_i,
    output logic              out_vld_o,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o,
    output logic [DATA_W-1:0] mq_o
);

    logic [SH_W-1:0]   shift_idx;
    logic              over_width;
    logic [DATA_W-1:0] core_res;
    logic [DATA_W-1:0] core_mq;
    logic              core_carry;

    // Amount select: immediate index never takes the over-width path.
    always_comb begin
        shift_idx  = imm_sel_i ? amt_imm_i : amt_reg_i[SH_W-1:0];
        over_width = amt_reg_i[AMT_W-1] & ~imm_sel_i;
    end

    mqsh_op_core #(.W(DATA_W), .SH_W(SH_W)) u_core (
        .op_i        (op_i),
        .src_i       (src_i),
        .amt_i       (shift_idx),
        .big_i       (over_width),
        .mq_i        (mq_o),
        .carry_i     (carry_o),
        .res_o       (core_res),
        .mq_nxt_o    (core_mq),
        .carry_nxt_o (core_carry)
    );

    // Output registers: operation updates all three; side port writes MQ when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_o <= 1'b0;
            res_o     <= '0;
            carry_o   <= 1'b0;
            mq_o      <= '0;
        end else begin
            out_vld_o <= in_vld_i;
            if (in_vld_i) begin
                res_o   <= core_res;
                carry_o <= core_carry;
                mq_o    <= core_mq;
            end else if (mq_we_i) begin
                mq_o    <= mq_wdata_i;
            end
        end
    end

endmodule

// File: rtl/mqsh_unit_chk.sv
// Module: property checker for mqsh_unit, attached with bind.
// Observes only the top-level ports and checks timing, hold and carry rules.
module mqsh_unit_chk
    import mqsh_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int AMT_W = SH_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld_i,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] src_i,
    input logic [AMT_W-1:0]  amt_reg_i,
    input logic              imm_sel_i,
    input logic              mq_we_i,
    input logic [DATA_W-1:0] mq_wdata_i,
    input logic              out_vld_o,
    input logic [DATA_W-1:0] res_o,
    input logic              carry_o,
    input logic [DATA_W-1:0] mq_o
);

    assert_vld_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i |=> out_vld_o);

    assert_vld_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld_i |=> !out_vld_o);

    assert_long_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && (op_i == 4'(MQOP_SHL_LONG) || op_i == 4'(MQOP_SHR_LONG))
         && amt_reg_i[AMT_W-1] && !imm_sel_i) |=> (res_o == '0));

    assert_fromq_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && (op_i == 4'(MQOP_SHL_FROMQ) || op_i == 4'(MQOP_SHR_FROMQ)))
        |=> $stable(mq_o));

    assert_carry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_vld_i && op_i == 4'(MQOP_SRA_CARRY)) |=> $stable(carry_o));

    assert_carry_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && op_i == 4'(MQOP_SRA_CARRY) && !src_i[DATA_W-1]) |=> !carry_o);

    assert_mq_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld_i && !mq_we_i) |=> $stable(mq_o));

    assert_side_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld_i && mq_we_i) |=> (mq_o == $past(mq_wdata_i)));

    assert_undef_op_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && op_i > 4'(MQOP_SRA_CARRY))
        |=> (res_o == '0 && $stable(mq_o) && $stable(carry_o)));

endmodule

bind mqsh_unit mqsh_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld_i   (in_vld_i),
    .op_i       (op_i),
    .src_i      (src_i),
    .amt_reg_i  (amt_reg_i),
    .imm_sel_i  (imm_sel_i),
    .mq_we_i    (mq_we_i),
    .mq_wdata_i (mq_wdata_i),
    .out_vld_o  (out_vld_o),
    .res_o      (res_o),
    .carry_o    (carry_o),
    .mq_o       (mq_o)
);

// File: tb/test_mqsh_unit.sv
// Bench: exhaustive sweep of mqsh_unit at DATA_W = 8 against an arithmetic model.
module test_mqsh_unit;

    localparam int BW = 8;

    logic          clk        = 1'b0;
    logic          rst_n      = 1'b0;
    logic          in_vld_i   = 1'b0;
    logic [3:0]    op_i       = '0;
    logic [BW-1:0] src_i      = '0;
    logic [3:0]    amt_reg_i  = '0;
    logic          imm_sel_i  = 1'b0;
    logic [2:0]    amt_imm_i  = '0;
    logic          mq_we_i    = 1'b0;
    logic [BW-1:0] mq_wdata_i = '0;
    logic          out_vld_o;
    logic [BW-1:0] res_o;
    logic          carry_o;
    logic [BW-1:0] mq_o;

    int n_chk = 0;
    int n_err = 0;

    logic [BW-1:0] m_mq    = '0;
    logic          m_carry = 1'b0;

    mqsh_unit #(.DATA_W(BW)) i_mqsh_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld_i   (in_vld_i),
        .op_i       (op_i),
        .src_i      (src_i),
        .amt_reg_i  (amt_reg_i),
        .imm_sel_i  (imm_sel_i),
        .amt_imm_i  (amt_imm_i),
        .mq_we_i    (mq_we_i),
        .mq_wdata_i (mq_wdata_i),
        .out_vld_o  (out_vld_o),
        .res_o      (res_o),
        .carry_o    (carry_o),
        .mq_o       (mq_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input int op);
        if (op <= 1) return "R3";
        if (op <= 3) return "R4";
        if (op <= 5) return "R5";
        if (op <= 7) return "R6";
        if (op == 8) return "R7";
        if (op == 9) return "R8";
        return "R13";
    endfunction

    // Arithmetic reference model of one operation.
    task automatic model(input logic [3:0] op, input logic [BW-1:0] src,
                         input logic [3:0] amt, input logic isel, input logic [2:0] imm,
                         output logic [BW-1:0] res, output logic [BW-1:0] mq1,
                         output logic c1);
        logic [2:0]       n;
        logic             big;
        logic [2*BW-1:0]  tl;
        logic [2*BW-1:0]  tr;
        logic [BW-1:0]    rl, rr, ml, mr, sar;
        logic signed [BW-1:0] ssrc;
        n    = isel ? imm : amt[2:0];
        big  = !isel && amt[3];
        tl   = {src, src} << n;
        tr   = {src, src} >> n;
        rl   = tl[2*BW-1:BW];
        rr   = tr[BW-1:0];
        ml   = 8'hFF << n;
        mr   = 8'hFF >> n;
        ssrc = src;
        sar  = ssrc >>> n;
        res  = '0;
        mq1  = m_mq;
        c1   = m_carry;
        case (op)
            4'd0: begin res = src << n; mq1 = rl; end
            4'd1: begin res = src >> n; mq1 = rr; end
            4'd2: begin res = big ? 8'h00 : src << n; mq1 = rl; end
            4'd3: begin res = big ? 8'h00 : src >> n; mq1 = rr; end
            4'd4: begin res = (rl & ml) | (m_mq & ~ml); mq1 = rl; end
            4'd5: begin res = (rr & mr) | (m_mq & ~mr); mq1 = rr; end
            4'd6: res = big ? (m_mq & ml) : ((src << n) | (m_mq & ~ml));
            4'd7: res = big ? (m_mq & mr) : ((src >> n) | (m_mq & ~mr));
            4'd8: begin res = sar; mq1 = rr; end
            4'd9: begin
                res = big ? {BW{src[BW-1]}} : sar;
                mq1 = rr;
                c1  = src[BW-1] && (big || ((src & ~ml) != 0));
            end
            default: res = '0;
        endcase
    endtask

    // Drive one operation at a falling edge, check at the next falling edge.
    task automatic run_op(input string tag, input logic [3:0] op, input logic [BW-1:0] src,
                          input logic [3:0] amt, input logic isel, input logic [2:0] imm);
        logic [BW-1:0] e_res, e_mq;
        logic          e_c;
        model(op, src, amt, isel, imm, e_res, e_mq, e_c);
        in_vld_i  = 1'b1;
        op_i      = op;
        src_i     = src;
        amt_reg_i = amt;
        imm_sel_i = isel;
        amt_imm_i = imm;
        @(negedge clk);
        in_vld_i = 1'b0;
        chk(tag, "result", 16'(res_o), 16'(e_res));
        chk(tag, "mq", 16'(mq_o), 16'(e_mq));
        chk(tag, "carry", 16'(carry_o), 16'(e_c));
        chk("R2", "out_vld", 16'(out_vld_o), 16'd1);
        m_mq    = e_mq;
        m_carry = e_c;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [BW-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "result", 16'(res_o), 16'd0);
        chk("R1", "mq", 16'(mq_o), 16'd0);
        chk("R1", "carry", 16'(carry_o), 16'd0);
        chk("R1", "out_vld", 16'(out_vld_o), 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "mq after release", 16'(mq_o), 16'd0);

        // R2: single-cycle valid pulse and result hold
        run_op("R3", 4'd0, 8'h5A, 4'd3, 1'b0, 3'd0);
        held = res_o;
        @(negedge clk);
        chk("R2", "out_vld drop", 16'(out_vld_o), 16'd0);
        chk("R2", "result hold", 16'(res_o), 16'(held));

        // R10: zero shift index on every defined code, register and immediate
        for (int op = 0; op < 10; op++) begin
            run_op("R10", 4'(op), 8'hB6, 4'd0, 1'b0, 3'd0);
            run_op("R10", 4'(op), 8'h93, 4'd9, 1'b1, 3'd0);
        end
        run_op("R10", 4'd9, 8'h80, 4'd0, 1'b0, 3'd0);
        chk("R10", "carry clear at zero", 16'(carry_o), 16'd0);

        // R12: side-port write while idle, then operation wins over side write
        mq_we_i = 1'b1; mq_wdata_i = 8'h3C;
        @(negedge clk);
        mq_we_i = 1'b0;
        chk("R12", "side write", 16'(mq_o), 16'h3C);
        m_mq = 8'h3C;
        @(negedge clk);
        chk("R12", "mq hold", 16'(mq_o), 16'h3C);
        mq_we_i = 1'b1; mq_wdata_i = 8'hFF;
        run_op("R12", 4'd0, 8'h81, 4'd1, 1'b0, 3'd0);
        mq_we_i = 1'b0;
        chk("R12", "op wins", 16'(mq_o), 16'h03);

        // R11: back-to-back merges, each seeing the previous MQ
        mq_we_i = 1'b1; mq_wdata_i = 8'hA5;
        @(negedge clk);
        mq_we_i = 1'b0;
        m_mq = 8'hA5;
        run_op("R11", 4'd4, 8'h0F, 4'd4, 1'b0, 3'd0);
        chk("R11", "first merge", 16'(res_o), 16'hF5);
        run_op("R11", 4'd4, 8'h12, 4'd2, 1'b0, 3'd0);
        chk("R11", "second merge", 16'(res_o), 16'h48);
        run_op("R11", 4'd5, 8'hC3, 4'd3, 1'b0, 3'd0);

        // Register-amount sweep: all codes, all amounts, all sources
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 16; a++)
                for (int s = 0; s < 256; s++)
                    run_op(op_tag(op), 4'(op), 8'(s), 4'(a), 1'b0, 3'd0);

        // R9: immediate sweep with the over-width bit held high and ignored
        for (int op = 0; op < 10; op++)
            for (int im = 0; im < 8; im++)
                for (int s = 0; s < 256; s += 3)
                    run_op("R9", 4'(op), 8'(s), 4'hF, 1'b1, 3'(im));

        @(negedge clk);
        finish_run();
    end

endmodule